// File: doc/BRIEF.md
# Control Endpoint OUT Receive Buffer

This block sits between a device-side protocol engine and firmware. It buffers the OUT data stage of a control transfer on endpoint 0. The protocol engine sends it decoded events: an OUT token strobe, a stream of payload bytes and an end-of-packet strobe. The block answers each packet with an ACK or NAK handshake pulse. It also reports, with a single pulse, that an IN token has closed the data stage.

Flow control works by holding the buffer until firmware releases it. The block takes a packet only when the buffer is free. Once a packet is accepted, the buffer is locked. Every later OUT packet is refused with NAK, and its payload is thrown away, until firmware writes the release trigger. Firmware sees a receive-done flag and an interrupt. It reads the byte count and pops the payload one byte per read. It clears flags by writing zeros to them. Then it writes 1 to the trigger, which empties the buffer for the next packet.

The processor side is a small register port. Its reads are combinational and its writes are single-cycle strobes. It has four addresses:

| Address | Name | Read | Write |
|---|---|---|---|
| 0 | flags | bit 0 is receive-done, bit 1 is overflow | a 0 in a bit clears that flag; a 1 leaves it unchanged |
| 1 | trigger | always 0 | a 1 in bit 0 releases the buffer |
| 2 | size | byte count | ignored |
| 3 | data | next byte, and the read pops it | ignored |

Top module: `ep0_out_rxbuf`

## Requirements
- R1: After reset the size register reads 0, the flags register reads 0, irq is low and the first OUT packet is acknowledged.
- R2: When the buffer is free, the block stores the bytes of an OUT packet and pulses hs_ack for exactly one cycle. The pulse appears on the clock edge that samples rx_eop. hs_nak stays low.
- R3: While the buffer is locked, an OUT packet gets a one-cycle hs_nak pulse and no hs_ack. Its bytes change neither the size register nor the stored payload.
- R4: An accepted packet sets flag bit 0 (receive-done). irq equals that bit.
- R5: Address 2 reads the number of stored bytes. Each read of address 3 returns the next stored byte, in arrival order, and advances the read position.
- R6: A read of address 3 after all stored bytes have been read returns 0. It does not move the read position.
- R7: Writing to address 0 clears each flag whose written bit is 0. A flag whose written bit is 1 is left unchanged.
- R8: Writing 1 to bit 0 of address 1 empties the buffer, so the size reads 0, and makes the next OUT packet acknowledged. Address 1 always reads 0.
- R9: In a packet longer than DEPTH bytes, the bytes beyond DEPTH are dropped. The size stays at DEPTH and flag bit 1 (overflow) is set.
- R10: An IN token after an OUT token produces a one-cycle stage_end pulse on the following edge. An IN token with no OUT token since the last IN token produces no pulse.
- R11: Payload bytes that arrive outside an OUT packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tok_out | input | 1 | OUT token strobe for endpoint 0 |
| tok_in | input | 1 | IN token strobe for endpoint 0 |
| rx_valid | input | 1 | payload byte valid |
| rx_byte | input | 8 | payload byte |
| rx_eop | input | 1 | end of data packet strobe |
| hs_ack | output | 1 | ACK handshake decision pulse |
| hs_nak | output | 1 | NAK handshake decision pulse |
| stage_end | output | 1 | data stage closed by IN token, one-cycle pulse |
| irq | output | 1 | interrupt request, equals receive-done flag |
| cpu_addr | input | 2 | register address |
| cpu_wr | input | 1 | register write strobe |
| cpu_rd | input | 1 | register read strobe (pops at address 3) |
| cpu_wdata | input | 2 | register write data |
| cpu_rdata | output | 8 | register read data |

## Verification
The bench builds the block with DEPTH=4. With that depth, the overflow cut-off is reached with packets of only five bytes. The bench sweeps every packet length from 0 to 7, so the empty, partial, exactly full and over-full cases are each covered in a few cycles. For each length it checks the handshake, the flags, the size and every popped byte against values computed from the length. It also checks the refusal of a packet while the buffer is locked, the release, and the stage-end pulse.

// File: rtl/ep0_out_rxbuf.sv
module ep0_out_rxbuf #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_out,
  input  logic       tok_in,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_eop,
  output logic       hs_ack,
  output logic       hs_nak,
  output logic       stage_end,
  output logic       irq,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [1:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_TRIG = 2'd1;
  localparam logic [1:0] A_SIZE = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wptr, rptr;
  logic             free, in_pkt, accept, stage_on;
  logic             rxdone, ovf;

  wire has_data = (rptr != wptr);
  wire pop      = cpu_rd && cpu_addr == A_DATA && has_data;
  wire trig     = cpu_wr && cpu_addr == A_TRIG && cpu_wdata[0];
  wire flag_wr  = cpu_wr && cpu_addr == A_FLAG;
  wire take     = in_pkt && accept && rx_valid;
  wire room     = wptr < FULL;

  assign irq = rxdone;

  always_ff @(posedge clk)
    if (take && room) mem[wptr[IDX_W-1:0]] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      free      <= 1'b1;
      in_pkt    <= 1'b0;
      accept    <= 1'b0;
      stage_on  <= 1'b0;
      rxdone    <= 1'b0;
      ovf       <= 1'b0;
      hs_ack    <= 1'b0;
      hs_nak    <= 1'b0;
      stage_end <= 1'b0;
    end else begin
      hs_ack    <= 1'b0;
      hs_nak    <= 1'b0;
      stage_end <= 1'b0;
      if (flag_wr) begin
        rxdone <= rxdone & cpu_wdata[0];
        ovf    <= ovf & cpu_wdata[1];
      end
      if (tok_out) begin
        in_pkt   <= 1'b1;
        accept   <= free;
        stage_on <= 1'b1;
      end
      if (tok_in) begin
        stage_end <= stage_on;
        stage_on  <= 1'b0;
      end
      if (take) begin
        if (room) wptr <= wptr + 1'b1;
        else      ovf  <= 1'b1;
      end
      if (in_pkt && rx_eop) begin
        in_pkt <= 1'b0;
        if (accept) begin
          hs_ack <= 1'b1;
          free   <= 1'b0;
          rxdone <= 1'b1;
        end else begin
          hs_nak <= 1'b1;
        end
      end
      if (pop) rptr <= rptr + 1'b1;
      if (trig) begin
        wptr <= '0;
        rptr <= '0;
        free <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cpu_addr)
      A_FLAG:  cpu_rdata = {6'd0, ovf, rxdone};
      A_SIZE:  cpu_rdata = 8'(wptr);
      A_DATA:  cpu_rdata = has_data ? mem[rptr[IDX_W-1:0]] : 8'd0;
      default: cpu_rdata = 8'd0;
    endcase
  end

  p_hs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));
  p_ack_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> (!free && rxdone));
  p_nak_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> $stable(wptr));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= FULL && rptr <= wptr);
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == A_DATA && !has_data) |=> $stable(rptr));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == A_TRIG && cpu_wdata[0]) |=> (free && wptr == '0));
  p_stage_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stage_end |-> !stage_on);
endmodule

// File: tb/test_ep0_out_rxbuf.sv
`timescale 1ns/1ps
module test_ep0_out_rxbuf;
  localparam int DEPTH = 4;
  logic clk = 0, rst_n = 0;
  logic tok_out = 0, tok_in = 0, rx_valid = 0, rx_eop = 0;
  logic [7:0] rx_byte = 0;
  logic hs_ack, hs_nak, stage_end, irq;
  logic [1:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_rdata;
  int checks = 0, errors = 0;
  logic got_ack, got_nak;

  always #4 clk = ~clk;

  ep0_out_rxbuf #(.DEPTH(DEPTH)) i_ep0_out_rxbuf (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .tok_in(tok_in),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .stage_end(stage_end), .irq(irq),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] v);
    @(negedge clk); cpu_addr = a; cpu_wdata = v; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0; cpu_wdata = 0;
  endtask

  task automatic send(input int len, input logic [7:0] base);
    @(negedge clk); tok_out = 1;
    @(negedge clk); tok_out = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_byte = base + 8'(i * 3);
      @(negedge clk);
    end
    rx_valid = 0; rx_eop = 1;
    @(negedge clk); rx_eop = 0;
    got_ack = hs_ack; got_nak = hs_nak;
    @(negedge clk);
    chk("R2 ack one cycle", int'(hs_ack), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd2, d); chk("R1 size", d, 0);
    rd(2'd0, d); chk("R1 flags", d, 0);
    chk("R1 irq", int'(irq), 0);
    // R11 stray bytes
    @(negedge clk); rx_valid = 1; rx_byte = 8'h5A;
    @(negedge clk); rx_valid = 0;
    rd(2'd2, d); chk("R11 stray ignored", d, 0);
    for (int len = 0; len <= DEPTH + 3; len++) begin
      logic [7:0] base;
      int n;
      base = 8'(16 * len + 1);
      n = (len > DEPTH) ? DEPTH : len;
      send(len, base);
      chk("R2 ack", int'(got_ack), 1);
      chk("R2 no nak", int'(got_nak), 0);
      chk("R4 irq", int'(irq), 1);
      rd(2'd0, d); chk("R4 R9 flags", d, (len > DEPTH) ? 3 : 1);
      rd(2'd2, d); chk("R5 R9 size", d, n);
      send(2, 8'hA0);
      chk("R3 nak", int'(got_nak), 1);
      chk("R3 no ack", int'(got_ack), 0);
      rd(2'd2, d); chk("R3 size kept", d, n);
      for (int i = 0; i < n; i++) begin
        rd(2'd3, d); chk("R5 data", d, int'(8'(base + 8'(i * 3))));
      end
      rd(2'd3, d); chk("R6 empty read", d, 0);
      rd(2'd3, d); chk("R6 empty read again", d, 0);
      wr(2'd0, 2'b11);
      rd(2'd0, d); chk("R7 write ones keeps", d, (len > DEPTH) ? 3 : 1);
      if (len > DEPTH) begin
        wr(2'd0, 2'b10);
        rd(2'd0, d); chk("R7 clear bit0 only", d, 2);
      end
      wr(2'd0, 2'b00);
      rd(2'd0, d); chk("R7 cleared", d, 0);
      chk("R7 irq low", int'(irq), 0);
      wr(2'd1, 2'b01);
      rd(2'd1, d); chk("R8 trigger reads 0", d, 0);
      rd(2'd2, d); chk("R8 size empty", d, 0);
    end
    // R10 stage end
    send(1, 8'h33);
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    chk("R10 stage_end pulse", int'(stage_end), 1);
    @(negedge clk);
    chk("R10 pulse width", int'(stage_end), 0);
    tok_in = 1;
    @(negedge clk); tok_in = 0;
    chk("R10 no pulse", int'(stage_end), 0);
    wr(2'd1, 2'b01);
    send(0, 8'h00);
    chk("R8 ack after release", int'(got_ack), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule